// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

This block gathers 32 asynchronous interrupt inputs and turns them into two processor interrupt lines, one critical and one non-critical. Each source is brought into the clock domain through a two-flop synchronizer. It can detect either edges or levels, of either polarity, and it latches an event into a status register that software clears by writing ones. An enable register masks sources from the outputs without stopping them from latching. A routing register sends each enabled source to either the critical line or the non-critical line.

Software reaches the configuration through a word-addressed register bus with separate read and write strobes. To service an interrupt, software reads the masked status or the pending-source index, clears the bit it has handled, and re-enables or reconfigures sources as it needs. A pending-index output names the highest-numbered pending enabled source. A valid flag beside it marks the case where nothing is pending, which is a spurious interrupt.

Top module: `irq_router`

## Requirements
- R1: Source n drives input pin irqIn[n] and occupies bit (31 - n) of every per-source register, so source 0 is the most significant bit. The word offsets are: 0x0 status, 0x2 enable, 0x3 critical route, 0x4 polarity, 0x5 trigger type, 0x6 masked status.
- R2: After reset the status, enable, critical route and trigger-type registers read 0, the polarity register reads all ones, both interrupt outputs are low and pendValid is low.
- R3: With trigger-type bit 1, a source latches its status bit on the selected transition of its synchronized input. Polarity 1 selects the rising edge and polarity 0 the falling edge. Once cleared, the bit stays clear until the next such transition.
- R4: With trigger-type bit 0, a source latches its status bit while its input is at the active level (high for polarity 1, low for polarity 0). Clearing the bit while the input is still active does not leave it clear, whether or not the source is enabled.
- R5: Writing offset 0x0 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When a source's set event and a software clear of the same status bit fall in the same clock cycle, the bit ends up set.
- R7: Offset 0x6 reads status AND enable and ignores writes. A source that is disabled still latches its status bit.
- R8: irqCritical is high one clock after any enabled pending source has its route bit at 1. irqNormal is high one clock after any enabled pending source has its route bit at 0.
- R9: pendValid is high exactly when masked status is non-zero. pendIdx then gives the highest-numbered enabled pending source, which is the least significant set bit of masked status.
- R10: Offsets other than 0x0 and 0x2 to 0x6 read as 0, and writes to them change no register.
- R11: Read data is captured on the clock edge at which busRdEn is high. It holds its value until the next read, even when registers change in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Word offset of the register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqIn | input | 32 | Raw asynchronous interrupt inputs, bit n is source n |
| irqNormal | output | 1 | Registered non-critical interrupt line |
| irqCritical | output | 1 | Registered critical interrupt line |
| pendIdx | output | 5 | Number of the highest-numbered enabled pending source |
| pendValid | output | 1 | Masked status is non-zero |

## Verification
The embedded properties check on every cycle that a clear without a set empties the bit, that a set event always lands even against a clear, that both output lines follow the previous cycle's masked and routed status, that the pending index points at the lowest set masked bit, and that the decoder never raises two write strobes. Only the bench's scenarios can show the behaviour seen from the bus and the pins. That covers the reversed bit numbering against the input pins, the latency through the synchronizer, level re-latching after a clear, ignored writes to read-only and unmapped offsets, and the register reset values.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int OFF_STATUS = 0;
  localparam int OFF_ENABLE = 2;
  localparam int OFF_CRIT   = 3;
  localparam int OFF_POL    = 4;
  localparam int OFF_TRIG   = 5;
  localparam int OFF_MASKED = 6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_CRIT,
    SEL_POL,
    SEL_TRIG,
    SEL_MASKED
  } regSel_e;

  typedef struct packed {
    logic    clrStatus;
    logic    wrEnable;
    logic    wrCrit;
    logic    wrPol;
    logic    wrTrig;
    logic    rdStrobe;
    regSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctrlStrb_t         strb
);

  regSel_e addrSel;

  always_comb begin
    addrSel = SEL_NONE;
    if (busAddr == ADDR_W'(OFF_STATUS))      addrSel = SEL_STATUS;
    else if (busAddr == ADDR_W'(OFF_ENABLE)) addrSel = SEL_ENABLE;
    else if (busAddr == ADDR_W'(OFF_CRIT))   addrSel = SEL_CRIT;
    else if (busAddr == ADDR_W'(OFF_POL))    addrSel = SEL_POL;
    else if (busAddr == ADDR_W'(OFF_TRIG))   addrSel = SEL_TRIG;
    else if (busAddr == ADDR_W'(OFF_MASKED)) addrSel = SEL_MASKED;
  end

  always_comb begin
    strb           = '0;
    strb.clrStatus = busWrEn && (addrSel == SEL_STATUS);
    strb.wrEnable  = busWrEn && (addrSel == SEL_ENABLE);
    strb.wrCrit    = busWrEn && (addrSel == SEL_CRIT);
    strb.wrPol     = busWrEn && (addrSel == SEL_POL);
    strb.wrTrig    = busWrEn && (addrSel == SEL_TRIG);
    strb.rdStrobe  = busRdEn;
    strb.rdSel     = addrSel;
  end

  // R10: an address selects at most one writable register
  assert_one_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clrStatus, strb.wrEnable, strb.wrCrit, strb.wrPol, strb.wrTrig}));

  // R7: the read-only offset never raises a write strobe
  assert_masked_ro_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFF_MASKED)) |->
      !(strb.clrStatus || strb.wrEnable || strb.wrCrit || strb.wrPol || strb.wrTrig));

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               irqNormal,
  output logic               irqCritical,
  output logic [IDX_W-1:0]   pendIdx,
  output logic               pendValid
);

  // Internal vectors use register bit order: source n lives at bit NUM_SRC-1-n.
  logic [NUM_SRC-1:0] rawOrd;
  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] statusQ, enableQ, critQ, polQ, trigQ;
  logic [NUM_SRC-1:0] setVec, maskedVec, clrMask;
  logic [NUM_SRC-1:0] rdDataQ;
  logic               irqNormalQ, irqCritQ;

  genvar n;
  generate
    for (n = 0; n < NUM_SRC; n++) begin : g_order
      assign rawOrd[NUM_SRC-1-n] = irqIn[n];
    end
  endgenerate

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= rawOrd;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  // Per-source detector: level or edge, polarity applied before detection
  generate
    for (n = 0; n < NUM_SRC; n++) begin : g_detect
      logic actNow, actPrev;
      assign actNow  = ~(syncQ[SYNC_STAGES-1][n] ^ polQ[n]);
      assign actPrev = ~(prevQ[n] ^ polQ[n]);
      assign setVec[n] = trigQ[n] ? (actNow & ~actPrev) : actNow;
    end
  endgenerate

  assign clrMask = strb.clrStatus ? busWrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      critQ   <= '0;
      polQ    <= '1;
      trigQ   <= '0;
    end else begin
      if (strb.wrEnable) enableQ <= busWrData;
      if (strb.wrCrit)   critQ   <= busWrData;
      if (strb.wrPol)    polQ    <= busWrData;
      if (strb.wrTrig)   trigQ   <= busWrData;
    end
  end

  assign maskedVec = statusQ & enableQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqNormalQ <= 1'b0;
      irqCritQ   <= 1'b0;
    end else begin
      irqNormalQ <= |(maskedVec & ~critQ);
      irqCritQ   <= |(maskedVec & critQ);
    end
  end

  assign irqNormal   = irqNormalQ;
  assign irqCritical = irqCritQ;

  // Lowest set bit of masked status maps to the highest-numbered source
  always_comb begin
    pendIdx   = '0;
    pendValid = 1'b0;
    for (int b = NUM_SRC-1; b >= 0; b--) begin
      if (maskedVec[b]) begin
        pendIdx   = IDX_W'(NUM_SRC-1-b);
        pendValid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdDataQ <= '0;
    else if (strb.rdStrobe) begin
      unique case (strb.rdSel)
        SEL_STATUS: rdDataQ <= statusQ;
        SEL_ENABLE: rdDataQ <= enableQ;
        SEL_CRIT:   rdDataQ <= critQ;
        SEL_POL:    rdDataQ <= polQ;
        SEL_TRIG:   rdDataQ <= trigQ;
        SEL_MASKED: rdDataQ <= maskedVec;
        default:    rdDataQ <= '0;
      endcase
    end
  end

  assign busRdData = rdDataQ;

  // R5: a clear with no competing set empties the bit
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStatus |=> ((statusQ & $past(busWrData & ~setVec)) == '0));

  // R6: a set event always lands, even against a clear
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((statusQ & $past(setVec)) == $past(setVec)));

  // R8: output lines follow the previous cycle's routed masked status
  assert_crit_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqCritical == $past(|(statusQ & enableQ & critQ))));
  assert_norm_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqNormal == $past(|(statusQ & enableQ & ~critQ))));

  // R9: the index points at a set masked bit with nothing set below it
  assert_pend_idx_R9: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> (maskedVec[NUM_SRC-1-int'(pendIdx)] &&
      ((maskedVec & ((NUM_SRC'(1) << (NUM_SRC-1-int'(pendIdx))) - NUM_SRC'(1))) == '0)));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               irqNormal,
  output logic               irqCritical,
  output logic [IDX_W-1:0]   pendIdx,
  output logic               pendValid
);

  ctrlStrb_t strb;

  irq_router_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  irq_router_dp #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .irqIn       (irqIn),
    .irqNormal   (irqNormal),
    .irqCritical (irqCritical),
    .pendIdx     (pendIdx),
    .pendValid   (pendValid)
  );

endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  busAddr;
  logic        busWrEn, busRdEn;
  logic [31:0] busWrData, busRdData, irqIn;
  logic        irqNormal, irqCritical, pendValid;
  logic [4:0]  pendIdx;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_router u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqIn(irqIn),
    .irqNormal(irqNormal), .irqCritical(irqCritical), .pendIdx(pendIdx), .pendValid(pendValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  // Pin vector (bit n = source n) to register order (source n at bit 31-n)
  function automatic logic [31:0] toReg(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] levelAct(input logic [31:0] v, pol, trig);
    return ~trig & ~(toReg(v) ^ pol);
  endfunction

  function automatic logic [31:0] edgeHits(input logic [31:0] v1, v2, pol, trig);
    logic [31:0] a, b;
    a = toReg(v1); b = toReg(v2);
    return trig & ((pol & ~a & b) | (~pol & a & ~b));
  endfunction

  function automatic logic [5:0] expPend(input logic [31:0] m);
    for (int b = 0; b < 32; b++) if (m[b]) return {1'b1, 5'(31 - b)};
    return 6'd0;
  endfunction

  task automatic checkOutputs(input string req, input logic [31:0] m, input logic [31:0] crit);
    check({req, " irqNormal"}, {31'd0, irqNormal}, {31'd0, |(m & ~crit)});
    check({req, " irqCritical"}, {31'd0, irqCritical}, {31'd0, |(m & crit)});
    check({req, " pend"}, {26'd0, pendValid, pendIdx}, {26'd0, expPend(m)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++; checkCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, en, crit, pol, trig, v, v2, expS;
    int seedDummy;
    seedDummy = $urandom(32'd1357);
    rstN = 1'b0; busAddr = '0; busWrEn = 0; busRdEn = 0; busWrData = '0; irqIn = '0;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);

    // R2: reset values
    busRead(4'h0, rd); check("R2 status", rd, 32'h0);
    busRead(4'h2, rd); check("R2 enable", rd, 32'h0);
    busRead(4'h3, rd); check("R2 crit", rd, 32'h0);
    busRead(4'h4, rd); check("R2 polarity", rd, 32'hFFFF_FFFF);
    busRead(4'h5, rd); check("R2 trig", rd, 32'h0);
    busRead(4'h6, rd); check("R2 masked", rd, 32'h0);
    checkOutputs("R2", 32'h0, 32'h0);

    // R1 and R9: bit order and pending index
    busWrite(4'h2, 32'h8000_0001);
    irqIn[0] = 1'b1;
    waitCyc(5);
    busRead(4'h0, rd); check("R1 source0 at bit31", rd, 32'h8000_0000);
    check("R9 idx source0", {26'd0, pendValid, pendIdx}, {26'd0, 1'b1, 5'd0});
    irqIn[31] = 1'b1;
    waitCyc(5);
    check("R9 idx highest-numbered", {26'd0, pendValid, pendIdx}, {26'd0, 1'b1, 5'd31});

    // R4: level source re-latches after clear even when disabled
    busWrite(4'h2, 32'h0);
    busWrite(4'h0, 32'hFFFF_FFFF);
    waitCyc(1);
    busRead(4'h0, rd); check("R4 active level re-latches", rd, 32'h8000_0001);
    busRead(4'h6, rd); check("R7 disabled masked", rd, 32'h0);
    irqIn = '0;
    waitCyc(4);
    busWrite(4'h0, 32'h0000_0001);
    busRead(4'h0, rd); check("R5 partial clear", rd, 32'h8000_0000);
    busWrite(4'h0, 32'h0);
    busRead(4'h0, rd); check("R5 zero write no effect", rd, 32'h8000_0000);
    busWrite(4'h0, 32'hFFFF_FFFF);
    busRead(4'h0, rd); check("R4 inactive stays clear", rd, 32'h0);

    // R7: write to masked ignored; R10: unmapped offsets
    busWrite(4'h2, 32'h1234_5678);
    busWrite(4'h6, 32'hFFFF_FFFF);
    busWrite(4'h1, 32'hFFFF_FFFF);
    busWrite(4'h9, 32'hFFFF_FFFF);
    busRead(4'h2, rd); check("R10 enable untouched", rd, 32'h1234_5678);
    busRead(4'h6, rd); check("R7 masked write ignored", rd, 32'h0);
    busRead(4'h1, rd); check("R10 offset1 reads zero", rd, 32'h0);
    busRead(4'h7, rd); check("R10 offset7 reads zero", rd, 32'h0);
    busRead(4'h0, rd); check("R10 status untouched", rd, 32'h0);

    // R11: read data holds after a register change
    busRead(4'h2, rd);
    busWrite(4'h2, 32'h0);
    waitCyc(2);
    check("R11 read data holds", busRdData, 32'h1234_5678);

    // R3: falling edge on source 5 (bit 26)
    busWrite(4'h4, ~32'h0400_0000);
    busWrite(4'h5, 32'h0400_0000);
    irqIn[5] = 1'b1;
    waitCyc(5);
    busWrite(4'h0, 32'hFFFF_FFFF);
    busRead(4'h0, rd); check("R3 steady high no event", rd, 32'h0);
    irqIn[5] = 1'b0;
    waitCyc(5);
    busRead(4'h0, rd); check("R3 falling edge latched", rd, 32'h0400_0000);
    busWrite(4'h0, 32'h0400_0000);
    irqIn[5] = 1'b1;
    waitCyc(5);
    busRead(4'h0, rd); check("R3 rising ignored after clear", rd, 32'h0);

    // R6: set event and clear in the same cycle (source 7 rising edge, bit 24)
    busWrite(4'h4, 32'hFFFF_FFFF);
    busWrite(4'h5, 32'h0100_0000);
    irqIn = '0;
    waitCyc(5);
    busWrite(4'h0, 32'hFFFF_FFFF);
    @(negedge clk); irqIn[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); busAddr = 4'h0; busWrData = 32'h0100_0000; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    busRead(4'h0, rd); check("R6 set wins over clear", rd, 32'h0100_0000);
    busWrite(4'h0, 32'h0100_0000);
    busRead(4'h0, rd); check("R6 later clear takes effect", rd, 32'h0);

    // Random configurations and input patterns: R3 R4 R7 R8 R9
    for (int it = 0; it < 24; it++) begin
      en = $urandom; crit = $urandom; pol = $urandom; trig = $urandom;
      v = $urandom; v2 = $urandom;
      busWrite(4'h2, en); busWrite(4'h3, crit);
      busWrite(4'h4, pol); busWrite(4'h5, trig);
      busRead(4'h3, rd); check("R1 route readback", rd, crit);
      irqIn = v;
      waitCyc(5);
      busWrite(4'h0, 32'hFFFF_FFFF);
      waitCyc(3);
      busRead(4'h0, rd); check("R4 random level after clear", rd, levelAct(v, pol, trig));
      irqIn = v2;
      waitCyc(5);
      expS = levelAct(v, pol, trig) | levelAct(v2, pol, trig) | edgeHits(v, v2, pol, trig);
      busRead(4'h0, rd); check("R3 random status", rd, expS);
      busRead(4'h6, rd); check("R7 random masked", rd, expS & en);
      checkOutputs("R8 R9 random", expS & en, crit);
      busWrite(4'h0, 32'hFFFF_FFFF);
      waitCyc(3);
      busRead(4'h0, rd); check("R4 random re-latch", rd, levelAct(v2, pol, trig));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule